// File: doc/BRIEF.md
# Delay-Line Tuning Code Controller

This block turns phase-correction pulses into the control words of a digitally controlled delay line. It holds a five-bit tuning position. An "advance" pulse moves the position up by one step and a "retard" pulse moves it down by one step. The position is confined to 28 legal values, 0 through 27, which gives 27 phase steps.

The position is decoded into two words. The first is an eight-line coarse tap select. It is registered, so every coarse line changes on the same clock edge as the position. The second is a four-bit fine interpolation word. The fine word is a thermometer code of the two low position bits, inverted when position bit 2 is set. As a result, the interpolation sweeps in opposite directions across neighbouring coarse taps and stays continuous at each tap boundary.

The synchronous reset is meant for initialisation only. It places the position at 14, the middle of the range, so the line starts with half its tuning range of delay.

Top module: `dly_tune_ctrl`

## Requirements
- R1: While reset is asserted (rst_n low at a clock edge), tune_count becomes 14, coarse_sel becomes 8'b0000_1000 and fine_code becomes 4'b1100.
- R2: When adv_pulse is 1 and ret_pulse is 0 at a clock edge and tune_count is below 27, tune_count rises by exactly one after that edge.
- R3: When ret_pulse is 1 and adv_pulse is 0 at a clock edge and tune_count is above 0, tune_count falls by exactly one after that edge.
- R4: When both pulses are 1, or both are 0, at a clock edge, tune_count keeps its value.
- R5: At tune_count = 27, an advance alone leaves the count at 27, so the count never exceeds 27.
- R6: At tune_count = 0, a retard alone leaves the count at 0.
- R7: In every cycle out of reset, coarse_sel is one-hot with bit k set where k = tune_count[4:2] (k in 0..6). coarse_sel[7] is never set, and coarse_sel changes in the same cycle as tune_count.
- R8: fine_code[i] = tune_count[2] XOR (tune_count[1:0] > i) for i = 0..3. fine_code follows tune_count combinationally in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low initialisation reset |
| adv_pulse | input | 1 | Request to step the position up by one |
| ret_pulse | input | 1 | Request to step the position down by one |
| coarse_sel | output | 8 | Registered one-hot coarse tap select |
| fine_code | output | 4 | Thermometer fine interpolation word |
| tune_count | output | 5 | Current tuning position |

## Verification
The bench drives the count into both ends and keeps pushing. A counter that wrapped would jump from 27 to 28 (an illegal coarse value) or from 0 to 31; one that clamped one code early would stall at 26 or at 1. Simultaneous advance and retard pulses are issued at several positions, and a design that gave one of them priority would drift. Random sequences cross every coarse boundary. These catch a coarse select decoded from the old position, which would lag the count by one cycle, and a fine word without the bit-2 inversion, which would jump by three thermometer steps at every odd tap.

// File: rtl/dly_tune_pkg.sv
// Package: shared sizing for the delay-line tuning controller.
// Assumes a legal range of 0..TUNE_MAX with the coarse index in the
// bits above FINE_LOG.
package dly_tune_pkg;
    localparam int TUNE_W   = 5;
    localparam int TUNE_MAX = 27;
    localparam int TUNE_MID = 14;
    localparam int FINE_LOG = 2;
    localparam int FINE_W   = 1 << FINE_LOG;
    localparam int COARSE_N = 1 << (TUNE_W - FINE_LOG);

    typedef logic [TUNE_W-1:0] tune_t;
endpackage

// File: rtl/tune_counter.sv
// Module: tune_counter
// Saturating up/down position counter. One step per clock. An advance and
// a retard in the same cycle cancel. Also exposes the next-state value so
// that downstream registers can load on the same edge.
// Assumes: MAX < 2**W, INIT <= MAX, reset used only for initialisation.
module tune_counter #(
    parameter int W    = 5,
    parameter int MAX  = 27,
    parameter int INIT = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         up,
    input  logic         dn,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cnt_nxt
);
    localparam logic [W-1:0] TOP  = W'(MAX);
    localparam logic [W-1:0] HOME = W'(INIT);

    // Next position: step, clamp at both ends, cancel on conflict.
    always_comb begin
        cnt_nxt = cnt;
        if (!rst_n)
            cnt_nxt = HOME;
        else if (up && !dn && cnt != TOP)
            cnt_nxt = cnt + W'(1);
        else if (dn && !up && cnt != '0)
            cnt_nxt = cnt - W'(1);
    end

    // Position register.
    always_ff @(posedge clk) begin
        cnt <= cnt_nxt;
    end

    p_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (up && !dn && cnt < TOP) |=> (cnt == W'($past(cnt) + 1)));
    p_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dn && !up && cnt > '0) |=> (cnt == W'($past(cnt) - 1)));
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (up == dn) |=> $stable(cnt));
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == TOP && up && !dn) |=> (cnt == TOP));
    p_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && dn && !up) |=> (cnt == '0));
endmodule

// File: rtl/coarse_decode.sv
// Module: coarse_decode
// Registered one-hot decoder of the upper position bits. It decodes the
// counter's next-state value, so every select line and the counter load on
// one edge and no line is skewed against another.
// Assumes: the index input never exceeds N-2 (the top line is unused).
module coarse_decode #(
    parameter int IDX_W = 3,
    parameter int N     = 8,
    parameter int INIT  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx_nxt,
    output logic [N-1:0]     sel
);
    logic [N-1:0] sel_nxt;

    // One comparator per line.
    for (genvar k = 0; k < N; k++) begin : g_line
        assign sel_nxt[k] = (idx_nxt == IDX_W'(k));
    end

    // Select register; reset drives the mid-range tap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel <= N'(1) << INIT;
        else
            sel <= sel_nxt;
    end

    p_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sel) == 1);
    p_top_unused_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !sel[N-1]);
endmodule

// File: rtl/fine_encode.sv
// Module: fine_encode
// Fine interpolation word: thermometer of the low position bits, inverted
// when the first coarse bit is set so the sweep reverses on alternate taps.
// Purely combinational.
module fine_encode #(
    parameter int LOG = 2,
    parameter int FW  = 4
) (
    input  logic [LOG:0] pos,
    output logic [FW-1:0] code
);
    logic [LOG-1:0] lvl;
    logic           flip;

    // Split position into level and direction bit.
    always_comb begin
        lvl  = pos[LOG-1:0];
        flip = pos[LOG];
    end

    for (genvar i = 0; i < FW; i++) begin : g_therm
        assign code[i] = flip ^ (int'(lvl) > i);
    end

    always_comb begin
        a_fine_ones_r8: assert ($countones(code) ==
            (flip ? FW - int'(lvl) : int'(lvl)));
    end
endmodule

// File: rtl/dly_tune_ctrl.sv
// Module: dly_tune_ctrl (top)
// Converts advance/retard pulses into coarse tap selects and a fine
// interpolation word for a delay line. Position range 0..27, reset to 14.
// Assumes: pulses are synchronous to clk, one step per cycle at most.
module dly_tune_ctrl
    import dly_tune_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                adv_pulse,
    input  logic                ret_pulse,
    output logic [COARSE_N-1:0] coarse_sel,
    output logic [FINE_W-1:0]   fine_code,
    output logic [TUNE_W-1:0]   tune_count
);
    localparam int IDX_W = TUNE_W - FINE_LOG;

    tune_t cnt_q;
    tune_t cnt_d;

    tune_counter #(.W(TUNE_W), .MAX(TUNE_MAX), .INIT(TUNE_MID)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .up      (adv_pulse),
        .dn      (ret_pulse),
        .cnt     (cnt_q),
        .cnt_nxt (cnt_d)
    );

    coarse_decode #(.IDX_W(IDX_W), .N(COARSE_N), .INIT(TUNE_MID >> FINE_LOG)) u_crs (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx_nxt (cnt_d[TUNE_W-1:FINE_LOG]),
        .sel     (coarse_sel)
    );

    fine_encode #(.LOG(FINE_LOG), .FW(FINE_W)) u_fin (
        .pos  (cnt_q[FINE_LOG:0]),
        .code (fine_code)
    );

    assign tune_count = cnt_q;

    p_coarse_tracks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        coarse_sel[cnt_q[TUNE_W-1:FINE_LOG]]);
    p_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= tune_t'(TUNE_MAX));
endmodule

// File: tb/sim_dly_tune_ctrl.sv
module sim_dly_tune_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       adv = 1'b0;
    logic       ret = 1'b0;
    logic [7:0] coarse;
    logic [3:0] fine;
    logic [4:0] cnt;

    int checks = 0;
    int fails  = 0;
    int exp_cnt = 14;
    bit done = 0;

    always #2 clk = ~clk;

    dly_tune_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .adv_pulse(adv), .ret_pulse(ret),
        .coarse_sel(coarse), .fine_code(fine), .tune_count(cnt)
    );

    function automatic logic [7:0] want_coarse(int c);
        return 8'(1) << (c / 4);
    endfunction

    function automatic logic [3:0] want_fine(int c);
        logic [3:0] t;
        int lv;
        lv = c % 4;
        for (int i = 0; i < 4; i++) t[i] = (lv > i);
        if (((c / 4) % 2) == 1) t = ~t;
        return t;
    endfunction

    function automatic int step(int c, bit a, bit r);
        if (a && !r && c < 27) return c + 1;
        if (r && !a && c > 0) return c - 1;
        return c;
    endfunction

    task automatic check_all(string tag);
        checks++;
        if (cnt !== 5'(exp_cnt)) begin
            fails++;
            $display("FAIL %s count: got %0d expected %0d", tag, cnt, exp_cnt);
        end
        checks++;
        if (coarse !== want_coarse(exp_cnt)) begin
            fails++;
            $display("FAIL %s/R7 coarse: got %b expected %b", tag, coarse, want_coarse(exp_cnt));
        end
        checks++;
        if (fine !== want_fine(exp_cnt)) begin
            fails++;
            $display("FAIL %s/R8 fine: got %b expected %b", tag, fine, want_fine(exp_cnt));
        end
    endtask

    task automatic drive(bit a, bit r, string tag);
        adv = a;
        ret = r;
        exp_cnt = step(exp_cnt, a, r);
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        int unused;
        unused = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");
        drive(1'b0, 1'b0, "R4");
        drive(1'b1, 1'b1, "R4");
        drive(1'b1, 1'b0, "R2");
        drive(1'b0, 1'b1, "R3");
        for (int i = 0; i < 16; i++) drive(1'b1, 1'b0, "R2");
        for (int i = 0; i < 3; i++) drive(1'b1, 1'b0, "R5");
        drive(1'b1, 1'b1, "R4");
        for (int i = 0; i < 30; i++) drive(1'b0, 1'b1, "R3");
        for (int i = 0; i < 3; i++) drive(1'b0, 1'b1, "R6");
        drive(1'b1, 1'b1, "R4");
        drive(1'b1, 1'b0, "R2");
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(0, 9);
            if (r < 4)      drive(1'b1, 1'b0, "R2");
            else if (r < 8) drive(1'b0, 1'b1, "R3");
            else if (r < 9) drive(1'b1, 1'b1, "R4");
            else            drive(1'b0, 1'b0, "R4");
        end
        rst_n = 1'b0;
        adv = 1'b0;
        ret = 1'b0;
        exp_cnt = 14;
        @(negedge clk);
        check_all("R1");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule